// File: doc/BRIEF.md
# Buffered Input Capture Timer

This block timestamps edges on four input pins. A 16-bit up-counter advances once every N bus cycles, where N is set by a programmable divider. Each capture pin first passes through a two-stage synchronizer and then through a delay filter. The filter accepts a new level only after the level has held for a selected number of cycles, and each accepted edge of the selected polarity copies the counter into that channel's capture register.

Each channel has two storage levels, a capture register and a holding register. Together they keep the two most recent timestamps, so software can read a pair of edges, such as the start and end of a pulse, without racing the pin.

A separate 16-bit down-counter with its own divider provides a periodic time base. When it steps from 1 to 0 it raises a flag and moves every capture register into its holding register in the same cycle. Software reads the counter's state and the flags through a single-cycle read/write register port.

Top module: `bufcap_timer`

## Requirements
- R1: After reset, all registers and all flags read 0.
- R2: Control register at address 0 holds the counter enable in bit 0 and a divide value P in bits 7:1.
  - While enabled, the counter at address 5 advances once every P+1 cycles; while disabled it holds its value.
  - The counter advancing from 0xFFFF to 0 sets flag bit 4.
- R3: The delay code of channel c sits in bits 9+2c:8+2c of address 1. Codes 0, 1, 2 and 3 give delays D of 1, 256, 512 and 1024 cycles.
  - A pin level held for at least D cycles is accepted.
  - The captured value equals the counter value read in the cycle the pin changed, plus D+1.
  - A level held for fewer than D cycles is never accepted.
- R4: The edge code of channel c sits in bits 2c+1:2c of address 1: 00 disabled, 01 rising, 10 falling, 11 both. Only accepted edges of the selected kind capture.
- R5: A capture into channel c follows three cases and sets flag bit c.
  - If the capture register is empty, the timestamp is loaded there.
  - If the capture register is full and the holding register is empty, the old value first moves to the holding register.
  - If both are full, the new timestamp overwrites the capture register.
- R6: Reading capture register c (address 8+c) marks it empty. Reading holding register c (address 12+c) marks it empty.
- R7: Modulus control at address 2 holds the enable in bit 0, the reload mode in bit 1 and a divide value Q in bits 5:2.
  - Writing address 3 sets both the load value and the count.
  - While enabled, the count decrements once every Q+1 cycles.
  - The step from 1 to 0 sets flag bit 5.
  - In reload mode the count reloads the load value instead of reaching 0; otherwise it stays at 0.
- R8: On that underflow step, every channel's holding register takes the capture value and that register's full state, and every capture register becomes empty.
- R9: Writing address 4 clears each flag whose data bit is 1 and leaves flags whose bit is 0 unchanged. A flag set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the read-to-empty side effects) |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr, combinational |
| cap_pin | input | 4 | Capture inputs, asynchronous |
| irq_cap | output | 4 | Per-channel capture flags |
| irq_ovf | output | 1 | Main counter overflow flag |
| irq_mod | output | 1 | Modulus underflow flag |

## Verification
The hardest states to reach are the two-deep queue states of a channel. One is both registers full, where a capture must overwrite. The other follows a modulus transfer, where the holding register is full and the capture register is empty, and a later capture must not push the transferred value out.

Directed steps run the down-counter to underflow with one pending timestamp. They then add two more captures without reading, so that a transfer that failed to mark the holding register full would show up as a wrong holding value.

Random pulses of random length and edge mode then build up queue occupancy. Random reads mixed between the pulses are checked against a bench model of the queue, and the reads also empty the registers.

// File: rtl/bct_pkg.sv
package bct_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    EDG_OFF  = 2'b00,
    EDG_RISE = 2'b01,
    EDG_FALL = 2'b10,
    EDG_BOTH = 2'b11
  } edge_sel_e;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_EDGE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MCTL  = 4'd2;
  localparam logic [ADDR_W-1:0] A_MOD   = 4'd3;
  localparam logic [ADDR_W-1:0] A_FLAG  = 4'd4;
  localparam logic [ADDR_W-1:0] A_TCNT  = 4'd5;
  localparam logic [ADDR_W-1:0] A_MLOAD = 4'd6;
  localparam int CAP_BASE  = 8;
  localparam int HOLD_BASE = 12;
endpackage

// File: rtl/bct_presc.sv
module bct_presc #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q >= div);
    cnt_d = cnt_q;
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bct_filter.sv
module bct_filter #(
  parameter int FBASE = 256,
  localparam int CW   = $clog2(FBASE * 4)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] dsel,
  output logic       acc,
  output logic       new_lvl
);
  logic s1_q, s2_q, lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    case (dsel)
      2'd0:    lim = '0;
      2'd1:    lim = CW'(FBASE - 1);
      2'd2:    lim = CW'(2 * FBASE - 1);
      default: lim = CW'(4 * FBASE - 1);
    endcase
  end

  always_comb begin
    acc     = 1'b0;
    lvl_d   = lvl_q;
    cnt_d   = cnt_q;
    new_lvl = s2_q;
    if (s2_q == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q >= lim) begin
      acc   = 1'b1;
      lvl_d = s2_q;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q  <= pin;
      s2_q  <= s1_q;
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/bct_chan.sv
module bct_chan #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_evt,
  input  logic [TW-1:0] tval,
  input  logic          xfer,
  input  logic          rd_cap,
  input  logic          rd_hold,
  output logic [TW-1:0] cap_q,
  output logic [TW-1:0] hold_q,
  output logic          capf_q,
  output logic          holdf_q
);
  logic [TW-1:0] cap_d, hold_d;
  logic          capf_d, holdf_d;

  always_comb begin
    cap_d   = cap_q;
    hold_d  = hold_q;
    capf_d  = capf_q;
    holdf_d = holdf_q;
    if (rd_cap)  capf_d  = 1'b0;
    if (rd_hold) holdf_d = 1'b0;
    if (xfer) begin
      hold_d  = cap_q;
      holdf_d = capf_q;
      capf_d  = 1'b0;
    end
    if (cap_evt) begin
      if (capf_d && !holdf_d) begin
        hold_d  = cap_q;
        holdf_d = 1'b1;
      end
      cap_d  = tval;
      capf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      hold_q  <= '0;
      capf_q  <= 1'b0;
      holdf_q <= 1'b0;
    end else begin
      cap_q   <= cap_d;
      hold_q  <= hold_d;
      capf_q  <= capf_d;
      holdf_q <= holdf_d;
    end
  end
endmodule

// File: rtl/bct_modcnt.sv
module bct_modcnt #(
  parameter int MW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          reload_mode,
  input  logic [PW-1:0] div,
  input  logic          ld_wr,
  input  logic [MW-1:0] ld_val,
  output logic [MW-1:0] cnt_q,
  output logic [MW-1:0] load_q,
  output logic          uf
);
  logic          tick;
  logic [MW-1:0] cnt_d, load_d;
  localparam logic [MW-1:0] ONE = MW'(1);

  bct_presc #(.W(PW)) u_mpsc (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .div  (div),
    .tick (tick)
  );

  always_comb begin
    cnt_d  = cnt_q;
    load_d = load_q;
    uf     = 1'b0;
    if (ld_wr) begin
      cnt_d  = ld_val;
      load_d = ld_val;
    end else if (tick && (cnt_q != '0)) begin
      if (cnt_q == ONE) begin
        uf    = 1'b1;
        cnt_d = reload_mode ? load_q : '0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      load_q <= load_d;
    end
  end
endmodule

// File: rtl/bufcap_timer.sv
module bufcap_timer
  import bct_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int TW    = 16,
  parameter int TPW   = 7,
  parameter int MPW   = 4,
  parameter int FBASE = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TW-1:0]     wdata,
  output logic [TW-1:0]     rdata,
  input  logic [NCH-1:0]    cap_pin,
  output logic [NCH-1:0]    irq_cap,
  output logic              irq_ovf,
  output logic              irq_mod
);
  localparam int FSH = 2 * NCH;
  localparam int OVB = NCH;
  localparam int MDB = NCH + 1;

  logic           tmr_en_q, tmr_en_d;
  logic [TPW-1:0] tpsc_q, tpsc_d;
  edge_sel_e      edge_q [NCH];
  edge_sel_e      edge_d [NCH];
  logic [1:0]     fsel_q [NCH];
  logic [1:0]     fsel_d [NCH];
  logic           men_q, men_d, mrl_q, mrl_d;
  logic [MPW-1:0] mpsc_q, mpsc_d;
  logic [TW-1:0]  tcnt_q, tcnt_d;
  logic [NCH-1:0] capflg_q, capflg_d;
  logic           ovf_q, ovf_d, modf_q, modf_d;

  logic wr_ctrl, wr_edge, wr_mctl, wr_mod, wr_flag;
  logic tmr_tick, ovf_evt, mod_uf;
  logic [TW-1:0]  mcnt, mload;
  logic [NCH-1:0] acc, lvl, cap_evt, capf, holdf, rd_cap, rd_hold;
  logic [TW-1:0]  capv  [NCH];
  logic [TW-1:0]  holdv [NCH];

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_edge = wr_en && (addr == A_EDGE);
  assign wr_mctl = wr_en && (addr == A_MCTL);
  assign wr_mod  = wr_en && (addr == A_MOD);
  assign wr_flag = wr_en && (addr == A_FLAG);

  bct_presc #(.W(TPW)) u_tpsc (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (tmr_en_q),
    .div  (tpsc_q),
    .tick (tmr_tick)
  );

  assign ovf_evt = tmr_tick && (tcnt_q == {TW{1'b1}});

  bct_modcnt #(.MW(TW), .PW(MPW)) u_mod (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (men_q),
    .reload_mode(mrl_q),
    .div        (mpsc_q),
    .ld_wr      (wr_mod),
    .ld_val     (wdata),
    .cnt_q      (mcnt),
    .load_q     (mload),
    .uf         (mod_uf)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    bct_filter #(.FBASE(FBASE)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin    (cap_pin[c]),
      .dsel   (fsel_q[c]),
      .acc    (acc[c]),
      .new_lvl(lvl[c])
    );

    always_comb begin
      case (edge_q[c])
        EDG_RISE: cap_evt[c] = acc[c] && lvl[c];
        EDG_FALL: cap_evt[c] = acc[c] && !lvl[c];
        EDG_BOTH: cap_evt[c] = acc[c];
        default:  cap_evt[c] = 1'b0;
      endcase
    end

    assign rd_cap[c]  = rd_en && (addr == ADDR_W'(CAP_BASE + c));
    assign rd_hold[c] = rd_en && (addr == ADDR_W'(HOLD_BASE + c));

    bct_chan #(.TW(TW)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_evt(cap_evt[c]),
      .tval   (tcnt_q),
      .xfer   (mod_uf),
      .rd_cap (rd_cap[c]),
      .rd_hold(rd_hold[c]),
      .cap_q  (capv[c]),
      .hold_q (holdv[c]),
      .capf_q (capf[c]),
      .holdf_q(holdf[c])
    );
  end

  always_comb begin
    tmr_en_d = tmr_en_q;
    tpsc_d   = tpsc_q;
    men_d    = men_q;
    mrl_d    = mrl_q;
    mpsc_d   = mpsc_q;
    for (int c = 0; c < NCH; c++) begin
      edge_d[c] = edge_q[c];
      fsel_d[c] = fsel_q[c];
    end
    if (wr_ctrl) begin
      tmr_en_d = wdata[0];
      tpsc_d   = wdata[TPW:1];
    end
    if (wr_edge) begin
      for (int c = 0; c < NCH; c++) begin
        edge_d[c] = edge_sel_e'(wdata[2*c +: 2]);
        fsel_d[c] = wdata[FSH + 2*c +: 2];
      end
    end
    if (wr_mctl) begin
      men_d  = wdata[0];
      mrl_d  = wdata[1];
      mpsc_d = wdata[MPW+1:2];
    end
    tcnt_d = tcnt_q + {{(TW-1){1'b0}}, tmr_tick};
  end

  always_comb begin
    capflg_d = capflg_q;
    ovf_d    = ovf_q;
    modf_d   = modf_q;
    if (wr_flag) begin
      capflg_d = capflg_q & ~wdata[NCH-1:0];
      if (wdata[OVB]) ovf_d  = 1'b0;
      if (wdata[MDB]) modf_d = 1'b0;
    end
    capflg_d = capflg_d | cap_evt;
    if (ovf_evt) ovf_d  = 1'b1;
    if (mod_uf)  modf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_en_q <= 1'b0;
      tpsc_q   <= '0;
      men_q    <= 1'b0;
      mrl_q    <= 1'b0;
      mpsc_q   <= '0;
      tcnt_q   <= '0;
      capflg_q <= '0;
      ovf_q    <= 1'b0;
      modf_q   <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        edge_q[c] <= EDG_OFF;
        fsel_q[c] <= 2'd0;
      end
    end else begin
      tmr_en_q <= tmr_en_d;
      tpsc_q   <= tpsc_d;
      men_q    <= men_d;
      mrl_q    <= mrl_d;
      mpsc_q   <= mpsc_d;
      tcnt_q   <= tcnt_d;
      capflg_q <= capflg_d;
      ovf_q    <= ovf_d;
      modf_q   <= modf_d;
      for (int c = 0; c < NCH; c++) begin
        edge_q[c] <= edge_d[c];
        fsel_q[c] <= fsel_d[c];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[0]     = tmr_en_q;
        rdata[TPW:1] = tpsc_q;
      end
      A_EDGE: begin
        for (int c = 0; c < NCH; c++) begin
          rdata[2*c +: 2]       = edge_q[c];
          rdata[FSH + 2*c +: 2] = fsel_q[c];
        end
      end
      A_MCTL: begin
        rdata[0]       = men_q;
        rdata[1]       = mrl_q;
        rdata[MPW+1:2] = mpsc_q;
      end
      A_MOD:   rdata = mcnt;
      A_FLAG: begin
        rdata[NCH-1:0] = capflg_q;
        rdata[OVB]     = ovf_q;
        rdata[MDB]     = modf_q;
      end
      A_TCNT:  rdata = tcnt_q;
      A_MLOAD: rdata = mload;
      default: begin
        for (int c = 0; c < NCH; c++) begin
          if (addr == ADDR_W'(CAP_BASE + c))  rdata = capv[c];
          if (addr == ADDR_W'(HOLD_BASE + c)) rdata = holdv[c];
        end
      end
    endcase
  end

  assign irq_cap = capflg_q;
  assign irq_ovf = ovf_q;
  assign irq_mod = modf_q;
endmodule

// File: rtl/bufcap_timer_chk.sv
module bufcap_timer_chk #(
  parameter int NCH = 4,
  parameter int TW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [3:0]     addr,
  input logic [TW-1:0]  wdata,
  input logic [NCH-1:0] irq_cap,
  input logic           irq_ovf,
  input logic           irq_mod,
  input logic           tmr_en,
  input logic           tick,
  input logic [TW-1:0]  tcnt,
  input logic [TW-1:0]  mcnt,
  input logic           mrl,
  input logic           mod_uf,
  input logic           mod_ld,
  input logic [NCH-1:0] cap_evt,
  input logic [NCH-1:0] capf
);
  AST_TCNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> $stable(tcnt)); // R2
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tcnt == {TW{1'b1}}) |=> irq_ovf); // R2
  AST_MOD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mcnt == '0 && !mrl && !mod_ld) |=> (mcnt == '0)); // R7
  AST_UF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    mod_uf |=> irq_mod); // R7
  AST_XFER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_uf && cap_evt == '0) |=> (capf == '0)); // R8
  AST_W1C_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd4 && wdata[NCH+1:0] == '1 && cap_evt == '0 && !mod_uf
     && !(tick && tcnt == {TW{1'b1}}))
    |=> (irq_cap == '0 && !irq_ovf && !irq_mod)); // R9
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && irq_mod) |=> irq_mod); // R9

  for (genvar c = 0; c < NCH; c++) begin : g_a
    AST_CAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[c] |=> (irq_cap[c] && capf[c])); // R5
  end
endmodule

bind bufcap_timer bufcap_timer_chk #(.NCH(NCH), .TW(TW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .addr   (addr),
  .wdata  (wdata),
  .irq_cap(irq_cap),
  .irq_ovf(irq_ovf),
  .irq_mod(irq_mod),
  .tmr_en (tmr_en_q),
  .tick   (tmr_tick),
  .tcnt   (tcnt_q),
  .mcnt   (mcnt),
  .mrl    (mrl_q),
  .mod_uf (mod_uf),
  .mod_ld (wr_mod),
  .cap_evt(cap_evt),
  .capf   (capf)
);

// File: tb/bufcap_timer_tb.sv
module bufcap_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [3:0]  addr;
  logic [15:0] wdata, rdata;
  logic [3:0]  cap_pin;
  logic [3:0]  irq_cap;
  logic        irq_ovf, irq_mod;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] m_cap  [NCH];
  logic [15:0] m_hold [NCH];
  bit m_cf [NCH];
  bit m_hf [NCH];
  bit m_ck [NCH];
  bit m_hk [NCH];

  bufcap_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cap_pin(cap_pin), .irq_cap(irq_cap),
    .irq_ovf(irq_ovf), .irq_mod(irq_mod)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input int ch, input int len, output logic [15:0] n);
    @(negedge clk);
    addr = 4'd5;
    #1 n = rdata;
    cap_pin[ch] = 1'b1;
    repeat (len) @(negedge clk);
    cap_pin[ch] = 1'b0;
  endtask

  function automatic void mcap(input int c, input logic [15:0] v);
    if (m_cf[c] && !m_hf[c]) begin
      m_hold[c] = m_cap[c]; m_hf[c] = 1'b1; m_hk[c] = m_ck[c];
    end
    m_cap[c] = v; m_cf[c] = 1'b1; m_ck[c] = 1'b1;
  endfunction

  function automatic void mxfer();
    for (int c = 0; c < NCH; c++) begin
      m_hold[c] = m_cap[c]; m_hk[c] = m_ck[c]; m_hf[c] = m_cf[c]; m_cf[c] = 1'b0;
    end
  endfunction

  task automatic rd_cap_chk(input int c, input string tag);
    logic [15:0] v;
    rd(4'(8 + c), v);
    if (m_ck[c]) chk(tag, v, m_cap[c]);
    m_cf[c] = 1'b0;
  endtask

  task automatic rd_hold_chk(input int c, input string tag);
    logic [15:0] v;
    rd(4'(12 + c), v);
    if (m_hk[c]) chk(tag, v, m_hold[c]);
    m_hf[c] = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] a, b, n, n0, na, nb;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; cap_pin = '0;
    for (int c = 0; c < NCH; c++) begin
      m_cf[c] = 0; m_hf[c] = 0; m_ck[c] = 0; m_hk[c] = 0; m_cap[c] = '0; m_hold[c] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(4'd4, a); chk("R1 flags", a, 16'h0);
    peek(4'd5, a); chk("R1 tcnt", a, 16'h0);
    peek(4'd3, a); chk("R1 mod", a, 16'h0);
    peek(4'd8, a); chk("R1 cap0", a, 16'h0);
    peek(4'd0, a); chk("R1 ctrl", a, 16'h0);

    // R2 counting rate and hold
    wr(4'd0, 16'h0001);
    peek(4'd5, a); repeat (17) @(negedge clk); peek(4'd5, b);
    chk("R2 div1", b - a, 16'd17);
    wr(4'd0, 16'h0001 | (16'd3 << 1));
    peek(4'd5, a); repeat (40) @(negedge clk); peek(4'd5, b);
    chk("R2 div4", b - a, 16'd10);
    wr(4'd0, 16'h0000);
    peek(4'd5, a); repeat (9) @(negedge clk); peek(4'd5, b);
    chk("R2 hold", b, a);

    // R2 overflow, R9 write-one-to-clear
    wr(4'd0, 16'h0001);
    wr(4'd4, 16'hFFFF);
    repeat (65536) @(negedge clk);
    peek(4'd4, a); chk("R2 overflow flag", {15'd0, a[4]}, 16'd1);
    wr(4'd4, 16'h0000);
    peek(4'd4, a); chk("R9 zero write keeps flag", {15'd0, a[4]}, 16'd1);
    wr(4'd4, 16'h0010);
    peek(4'd4, a); chk("R9 one write clears flag", {15'd0, a[4]}, 16'd0);

    // R3 delay filter on channel 1, rising edges
    wr(4'd1, (16'h1 << 2) | (16'h1 << 10));
    pulse(1, 255, n); repeat (300) @(negedge clk);
    peek(4'd4, a); chk("R3 short pulse 256 rejected", {15'd0, a[1]}, 16'd0);
    pulse(1, 256, n); repeat (5) @(negedge clk);
    peek(4'd4, a); chk("R3 pulse 256 flag", {15'd0, a[1]}, 16'd1);
    rd(4'd9, a); chk("R3 value 256", a, n + 16'd257);
    wr(4'd4, 16'hFFFF);
    wr(4'd1, (16'h1 << 2) | (16'h3 << 10));
    pulse(1, 1023, n); repeat (1100) @(negedge clk);
    peek(4'd4, a); chk("R3 short pulse 1024 rejected", {15'd0, a[1]}, 16'd0);
    pulse(1, 1024, nb); repeat (1100) @(negedge clk);
    rd(4'd9, a); chk("R3 value 1024", a, nb + 16'd1025);

    // R4 edge selection
    wr(4'd4, 16'hFFFF);
    wr(4'd1, 16'h2 << 4);
    pulse(2, 5, n); repeat (6) @(negedge clk);
    rd(4'd10, a); chk("R4 falling edge value", a, n + 16'd7);
    pulse(3, 4, n); repeat (6) @(negedge clk);
    peek(4'd4, a); chk("R4 disabled channel no flag", {15'd0, a[3]}, 16'd0);
    wr(4'd1, 16'h1 << 6);
    pulse(3, 4, n); repeat (6) @(negedge clk);
    rd(4'd11, a); chk("R4 rising edge value", a, n + 16'd2);

    // R7 modulus counter
    wr(4'd4, 16'hFFFF);
    wr(4'd2, 16'h0001);
    wr(4'd3, 16'd10);
    peek(4'd3, a); chk("R7 load", a, 16'd10);
    repeat (4) @(negedge clk); peek(4'd3, a); chk("R7 count down", a, 16'd6);
    repeat (5) @(negedge clk); peek(4'd4, a); chk("R7 no flag before zero", {15'd0, a[5]}, 16'd0);
    repeat (1) @(negedge clk); peek(4'd3, a); chk("R7 reached zero", a, 16'd0);
    peek(4'd4, a); chk("R7 underflow flag", {15'd0, a[5]}, 16'd1);
    repeat (5) @(negedge clk); peek(4'd3, a); chk("R7 stops at zero", a, 16'd0);
    wr(4'd4, 16'hFFFF);
    wr(4'd2, 16'h0003);
    wr(4'd3, 16'd5);
    repeat (5) @(negedge clk); peek(4'd3, a); chk("R7 reload", a, 16'd5);
    peek(4'd4, a); chk("R7 reload flag", {15'd0, a[5]}, 16'd1);
    repeat (1) @(negedge clk); peek(4'd3, a); chk("R7 after reload", a, 16'd4);
    wr(4'd2, 16'h0001 | (16'd1 << 2));
    wr(4'd3, 16'd8);
    repeat (10) @(negedge clk); peek(4'd3, a); chk("R7 divided rate", a, 16'd3);
    wr(4'd2, 16'h0000);

    // R8 transfer into holding registers, R5 queue after transfer
    for (int c = 0; c < NCH; c++) begin
      m_cf[c] = 0; m_hf[c] = 0; m_ck[c] = 0; m_hk[c] = 0;
    end
    wr(4'd1, 16'h0001);
    pulse(0, 3, n0); mcap(0, n0 + 16'd2); repeat (6) @(negedge clk);
    wr(4'd2, 16'h0001);
    wr(4'd3, 16'd3);
    repeat (5) @(negedge clk);
    wr(4'd2, 16'h0000);
    mxfer();
    pulse(0, 3, na); mcap(0, na + 16'd2); repeat (6) @(negedge clk);
    pulse(0, 3, nb); mcap(0, nb + 16'd2); repeat (6) @(negedge clk);
    rd_hold_chk(0, "R8 hold keeps transferred value");
    rd_cap_chk(0, "R5 overwrite when both full");
    chk("R8 expected hold is first stamp", m_hold[0], n0 + 16'd2);

    // R5 R6 random pulses against the queue model
    wr(4'd4, 16'hFFFF);
    for (int it = 0; it < 150; it++) begin
      int c, md, len, act;
      c = int'($urandom % NCH);
      md = int'($urandom % 4);
      len = 1 + int'($urandom % 4);
      wr(4'd1, 16'(md << (2 * c)));
      pulse(c, len, n);
      if (md == 1 || md == 3) mcap(c, n + 16'd2);
      if (md == 2 || md == 3) mcap(c, n + 16'(len) + 16'd2);
      repeat (4) @(negedge clk);
      peek(4'd4, a);
      chk("R5 capture flag", {15'd0, a[c]}, (md != 0) ? 16'd1 : 16'd0);
      wr(4'd4, 16'(1 << c));
      act = int'($urandom % 3);
      if (act == 0) rd_cap_chk(c, "R6 random capture read");
      else if (act == 1) rd_hold_chk(c, "R6 random hold read");
    end
    for (int c = 0; c < NCH; c++) begin
      rd_hold_chk(c, "R5 final hold");
      rd_cap_chk(c, "R5 final capture");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule